// File: doc/BRIEF.md
# Programmable Logic Cluster

This block is the logic tile of an island-style programmable fabric. It holds a parameterised number of identical logic elements. Each element has a 4-input lookup table, a D flip-flop clocked by the single cluster clock, and a configuration bit that picks whether the element drives its output from the table or from the flip-flop. All elements are interchangeable, so a mapped function may sit in any element position.

A fully connected local crossbar feeds the table pins. Every one of the 4·N table pins has its own multiplexer. The multiplexer can select any cluster input or the registered state of any element, including the element's own register. There may be fewer cluster inputs than table pins, so one input net can fan out to many pins inside the tile. When the cluster holds a single element there is no crossbar, and the table pins connect straight to the low cluster inputs.

The tile is programmed through one serial shift chain, loaded most significant bit first while `config_en` is high. Loading never changes the flip-flop contents.

Top module: `logic_cluster`

## Requirements
- R1: An element whose output-select bit is 0 drives the bit of its 16-bit table mask at index {pin3, pin2, pin1, pin0}, where pin0 is the least significant index bit.
- R2: An element whose output-select bit is 1 drives its flip-flop value. That value is the table result captured at the previous rising clock edge.
- R3: A crossbar select code c drives its pin from cluster input c when c < N_IN. It drives the pin from the flip-flop of element c−N_IN when N_IN ≤ c < N_IN+N_ELEM. Any larger code drives logic 0. Several pins may select the same source.
- R4: While `config_en` is high, each rising edge shifts `config_in` into the chain. The first bit shifted ends at the most significant position. Element 0 comes first, then element 1, and so on. Each element contributes, in this order: table mask bits 15 down to 0, then its output-select bit, then the select fields for pins 0 to 3. Each field is ceil(log2(N_IN+N_ELEM)) bits wide and is sent MSB first. While `config_en` is low, the chain holds its value.
- R5: When `config_en` is low, every flip-flop captures its table result on each rising edge. While `config_en` is high, all flip-flops hold their value.
- R6: A low `rst_n` sampled at a rising edge clears every flip-flop and every configuration bit to 0.
- R7: With N_ELEM = 1 there are no select fields and the chain is 17 bits long. Table pin k is cluster input k, or logic 0 when k ≥ N_IN.
- R8: An element's registered state can feed back to its own table pins and to those of other elements. This allows sequential functions such as a toggle to be built inside the tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock shared by all flip-flops and the chain |
| rst_n | input | 1 | Synchronous active-low reset |
| config_en | input | 1 | Shift enable for the configuration chain; freezes the flip-flops |
| config_in | input | 1 | Serial configuration data, MSB first |
| cl_in | input | N_IN | Cluster logic inputs |
| cl_out | output | N_ELEM | One output per logic element |

## Verification
Configuration shifting and state capture can both fall on the same clock edge. A flip-flop must ignore every edge on which the chain shifts, even though its table result changes with every partial configuration. The bench provokes this by reloading the tile while elements toggle through register feedback and the cluster inputs keep changing on every shift cycle. The new configuration puts elements in registered mode. The first outputs after loading must then equal the state the reference model froze before the load, and later cycles must follow the model cycle by cycle.

// File: rtl/lc_pkg.sv
// Shared constants and sizing functions for the logic cluster.
// Assumes a fixed 4-input table; all other widths derive from the
// cluster input count and the element count.
package lc_pkg;

    localparam int LUT_K    = 4;
    localparam int LUT_BITS = 1 << LUT_K;

    // Width of one crossbar select field for a given source count.
    function automatic int sel_width(input int n_in, input int n_elem);
        return (n_in + n_elem <= 2) ? 1 : $clog2(n_in + n_elem);
    endfunction

    // Configuration bits held per element: mask, output select, fields.
    function automatic int elem_cfg_width(input int n_in, input int n_elem);
        return LUT_BITS + 1 + ((n_elem > 1) ? LUT_K * sel_width(n_in, n_elem) : 0);
    endfunction

endpackage

// File: rtl/lc_cfg_chain.sv
// Serial configuration store of the cluster.
// Shifts one bit in at the LSB per enabled clock, so the first bit sent
// ends at the MSB. Cleared by the synchronous active-low reset.
module lc_cfg_chain #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_in,
    output logic [CFG_W-1:0] chain_q
);

    // Shift register holding every configuration bit of the tile.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (shift_en) begin
            chain_q <= {chain_q[CFG_W-2:0], shift_in};
        end
    end

endmodule

// File: rtl/lc_xbar_mux.sv
// One crossbar multiplexer feeding a single table pin.
// Sources are packed as {element registers, cluster inputs}; a select
// code past the last source yields logic 0.
module lc_xbar_mux #(
    parameter int N_SRC = 4,
    parameter int SEL_W = 2
) (
    input  logic [N_SRC-1:0] src,
    input  logic [SEL_W-1:0] sel,
    output logic             pin
);

    // Pick the addressed source or force 0 for unused codes.
    always_comb begin
        if (int'(sel) < N_SRC) begin
            pin = src[sel];
        end else begin
            pin = 1'b0;
        end
    end

endmodule

// File: rtl/lc_ble.sv
// Basic logic element: a K-input lookup table, a D flip-flop and an
// output selector. Assumes the caller freezes the register via hold
// while the configuration changes.
module lc_ble #(
    parameter int K = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic [(1<<K)-1:0]   mask,
    input  logic                reg_sel,
    input  logic [K-1:0]        pins,
    output logic                lut_o,
    output logic                ff_q,
    output logic                ble_out
);

    // Table lookup: pins form the mask index, pin 0 as LSB.
    assign lut_o = mask[pins];

    // State register: clears on reset, holds during configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q <= 1'b0;
        end else if (!hold) begin
            ff_q <= lut_o;
        end
    end

    // Output selection between registered and direct table result.
    assign ble_out = reg_sel ? ff_q : lut_o;

endmodule

// File: rtl/logic_cluster.sv
// Programmable logic cluster: N_ELEM identical elements, a fully
// connected crossbar from cluster inputs and element registers to every
// table pin, and a serial configuration chain. Feedback taps the element
// registers, so the tile has no combinational loop. With one element the
// crossbar is omitted and pins connect to the low cluster inputs.
module logic_cluster #(
    parameter int N_ELEM = 4,
    parameter int N_IN   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              config_en,
    input  logic              config_in,
    input  logic [N_IN-1:0]   cl_in,
    output logic [N_ELEM-1:0] cl_out
);

    import lc_pkg::*;

    localparam int SEL_W  = sel_width(N_IN, N_ELEM);
    localparam int N_SRC  = N_IN + N_ELEM;
    localparam int ELEM_W = elem_cfg_width(N_IN, N_ELEM);
    localparam int CFG_W  = N_ELEM * ELEM_W;
    localparam int XBAR_W = ELEM_W - LUT_BITS - 1;

    logic [CFG_W-1:0]  chain_q;
    logic [N_ELEM-1:0] ff_q;
    logic [N_ELEM-1:0] lut_o;
    logic [N_SRC-1:0]  xbar_src;

    // Crossbar source vector: registers above cluster inputs.
    assign xbar_src = {ff_q, cl_in};

    lc_cfg_chain #(
        .CFG_W (CFG_W)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (config_en),
        .shift_in (config_in),
        .chain_q  (chain_q)
    );

    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
        localparam int TOP = (N_ELEM - e) * ELEM_W - 1;
        logic [ELEM_W-1:0] slice;
        logic [LUT_K-1:0]  pins;

        // Configuration slice owned by this element.
        assign slice = chain_q[TOP -: ELEM_W];

        if (N_ELEM > 1) begin : g_xbar
            for (genvar k = 0; k < LUT_K; k++) begin : g_pin
                lc_xbar_mux #(
                    .N_SRC (N_SRC),
                    .SEL_W (SEL_W)
                ) u_mux (
                    .src (xbar_src),
                    .sel (slice[XBAR_W-1-k*SEL_W -: SEL_W]),
                    .pin (pins[k])
                );
            end
        end else begin : g_direct
            for (genvar k = 0; k < LUT_K; k++) begin : g_pin
                if (k < N_IN) begin : g_wire
                    assign pins[k] = cl_in[k];
                end else begin : g_zero
                    assign pins[k] = 1'b0;
                end
            end
        end

        lc_ble #(
            .K (LUT_K)
        ) u_ble (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (config_en),
            .mask    (slice[ELEM_W-1 -: LUT_BITS]),
            .reg_sel (slice[ELEM_W-1-LUT_BITS]),
            .pins    (pins),
            .lut_o   (lut_o[e]),
            .ff_q    (ff_q[e]),
            .ble_out (cl_out[e])
        );
    end

endmodule

// File: rtl/lc_checker.sv
// Temporal checks on the cluster's chain and element registers.
// Attached to every logic_cluster instance through the bind below.
module lc_checker #(
    parameter int N_ELEM = 4,
    parameter int CFG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              config_en,
    input logic              config_in,
    input logic [CFG_W-1:0]  chain_q,
    input logic [N_ELEM-1:0] ff_q,
    input logic [N_ELEM-1:0] lut_o
);

    AST_RST_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (ff_q == '0 && chain_q == '0)); // R6

    AST_FF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        config_en |=> $stable(ff_q)); // R5

    AST_FF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !config_en |=> (ff_q == $past(lut_o))); // R5

    AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        config_en |=> (chain_q == {$past(chain_q[CFG_W-2:0]), $past(config_in)})); // R4

    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !config_en |=> $stable(chain_q)); // R4

endmodule

bind logic_cluster lc_checker #(
    .N_ELEM (N_ELEM),
    .CFG_W  (CFG_W)
) u_lc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .config_en (config_en),
    .config_in (config_in),
    .chain_q   (chain_q),
    .ff_q      (ff_q),
    .lut_o     (lut_o)
);

// File: tb/logic_cluster_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a 4-element cluster against a reference model,
// plus a single-element instance for the direct-wired case.
module logic_cluster_tb;

    localparam int NI = 10;
    localparam int NE = 4;
    localparam int K  = 4;
    localparam int SW = $clog2(NI + NE);
    localparam int EW = 16 + 1 + K * SW;
    localparam int CW = NE * EW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, config_en, config_in;
    logic [NI-1:0] cl_in;
    logic [NE-1:0] cl_out;
    logic          rst1_n, cfg1_en, cfg1_in;
    logic [3:0]    in1;
    logic [0:0]    out1;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0]   m_lut  [NE];
    logic          m_osel [NE];
    int            m_sel  [NE][K];
    logic [NE-1:0] m_q;
    logic [15:0]   m1_lut;
    logic          m1_osel;
    logic          m1_q;

    logic_cluster #(.N_ELEM(NE), .N_IN(NI)) u_dut (
        .clk(clk), .rst_n(rst_n), .config_en(config_en),
        .config_in(config_in), .cl_in(cl_in), .cl_out(cl_out));

    logic_cluster #(.N_ELEM(1), .N_IN(4)) u_dut_single (
        .clk(clk), .rst_n(rst1_n), .config_en(cfg1_en),
        .config_in(cfg1_in), .cl_in(in1), .cl_out(out1));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference table results for every element (R1, R3, R8).
    function automatic logic [NE-1:0] model_lut(input logic [NI-1:0] din);
        logic [NE-1:0] r;
        for (int e = 0; e < NE; e++) begin
            logic [3:0] idx;
            for (int k = 0; k < K; k++) begin
                int s = m_sel[e][k];
                if (s < NI)           idx[k] = din[s];
                else if (s < NI + NE) idx[k] = m_q[s-NI];
                else                  idx[k] = 1'b0;
            end
            r[e] = m_lut[e][idx];
        end
        return r;
    endfunction

    // Chain image in the order of R4.
    function automatic logic [CW-1:0] pack_cfg();
        logic [CW-1:0] v;
        int pos = CW - 1;
        for (int e = 0; e < NE; e++) begin
            for (int b = 15; b >= 0; b--) begin v[pos] = m_lut[e][b]; pos--; end
            v[pos] = m_osel[e]; pos--;
            for (int k = 0; k < K; k++)
                for (int b = SW - 1; b >= 0; b--) begin v[pos] = m_sel[e][k][b]; pos--; end
        end
        return v;
    endfunction

    // Shift a configuration in while inputs keep changing (R4, R5).
    task automatic load_cfg();
        logic [CW-1:0] bits = pack_cfg();
        for (int b = CW - 1; b >= 0; b--) begin
            @(negedge clk);
            rst_n = 1'b1; config_en = 1'b1; config_in = bits[b];
            cl_in = NI'($urandom);
        end
    endtask

    // One functional cycle compared against the model (R1 R2 R3 R8).
    task automatic run_cycle(input logic [NI-1:0] din, input string tag);
        logic [NE-1:0] lv, exp;
        @(negedge clk);
        rst_n = 1'b1; config_en = 1'b0; cl_in = din;
        #1;
        lv = model_lut(din);
        for (int e = 0; e < NE; e++) exp[e] = m_osel[e] ? m_q[e] : lv[e];
        check(tag, 32'(cl_out), 32'(exp));
        @(posedge clk); #1;
        m_q = lv;
    endtask

    task automatic set_uniform(input logic [15:0] lut, input logic osel, input int sel);
        for (int e = 0; e < NE; e++) begin
            m_lut[e] = lut; m_osel[e] = osel;
            for (int k = 0; k < K; k++) m_sel[e][k] = sel;
        end
    endtask

    task automatic one_cycle(input logic [3:0] din);
        logic lv;
        @(negedge clk);
        rst1_n = 1'b1; cfg1_en = 1'b0; in1 = din;
        #1;
        lv = m1_lut[din];
        check("R7 single element", 32'(out1), 32'(m1_osel ? m1_q : lv));
        @(posedge clk); #1;
        m1_q = lv;
    endtask

    task automatic load1();
        logic [16:0] bits = {m1_lut, m1_osel};
        for (int b = 16; b >= 0; b--) begin
            @(negedge clk);
            rst1_n = 1'b1; cfg1_en = 1'b1; cfg1_in = bits[b]; in1 = 4'($urandom);
        end
    endtask

    initial begin
        #(5ns * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; config_en = 1'b0; config_in = 1'b0; cl_in = '0;
        rst1_n = 1'b0; cfg1_en = 1'b0; cfg1_in = 1'b0; in1 = '0;
        set_uniform(16'h0000, 1'b0, 0);
        m_q = '0; m1_q = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R6: outputs at reset with a cleared configuration.
        check("R6 reset outputs", 32'(cl_out), 32'h0);
        check("R6 reset single", 32'(out1), 32'h0);

        // R7: direct pins, parity table, combinational then registered.
        m1_lut = 16'h6996; m1_osel = 1'b0;
        load1();
        for (int i = 0; i < 12; i++) one_cycle(4'($urandom));
        m1_osel = 1'b1;
        load1();
        for (int i = 0; i < 12; i++) one_cycle(4'($urandom));

        // R3: out-of-range codes give 0, so index 0 selects mask bit 0.
        set_uniform(16'h0001, 1'b0, NI + NE);
        m_sel[1][2] = (1 << SW) - 1;
        load_cfg();
        for (int i = 0; i < 4; i++) run_cycle(NI'($urandom), "R3 out-of-range select");

        // R3: one input fanned out to every pin; mask 8000 gives in[3].
        set_uniform(16'h8000, 1'b0, 3);
        load_cfg();
        for (int i = 0; i < 8; i++) run_cycle(NI'($urandom), "R3 fan-out");

        // R8: each element toggles through its own register.
        set_uniform(16'h5555, 1'b1, NI + NE);
        for (int e = 0; e < NE; e++) m_sel[e][0] = NI + e;
        m_sel[2][1] = NI + 0;
        load_cfg();
        for (int i = 0; i < 7; i++) run_cycle(NI'($urandom), "R8 feedback toggle");

        // R5: reload with registered outputs while state is nonzero.
        set_uniform(16'hFFFF, 1'b1, NI + NE);
        load_cfg();
        run_cycle(NI'($urandom), "R5 state held through load");
        run_cycle(NI'($urandom), "R5 capture after load");

        // R1 R2 R3 R8: random configurations.
        for (int c = 0; c < 30; c++) begin
            for (int e = 0; e < NE; e++) begin
                m_lut[e] = 16'($urandom);
                m_osel[e] = 1'($urandom);
                for (int k = 0; k < K; k++) m_sel[e][k] = int'($urandom_range(0, (1 << SW) - 1));
            end
            load_cfg();
            for (int i = 0; i < 20; i++) run_cycle(NI'($urandom), "R1 R2 R3 R8 random");
        end

        // R6: mid-run reset clears state and configuration.
        @(negedge clk);
        rst_n = 1'b0; config_en = 1'b0;
        @(posedge clk); #1;
        m_q = '0;
        set_uniform(16'h0000, 1'b0, 0);
        check("R6 outputs after reset", 32'(cl_out), 32'h0);
        set_uniform(16'h0000, 1'b1, 0);
        load_cfg();
        run_cycle(NI'($urandom), "R6 registers cleared");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule